// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and takes the memory from power-on to a usable state. After reset it holds the clock-enable line low and waits for a start request. It then counts out the stabilization interval, raises clock enable behind a no-operation cycle, and issues the initialization commands in a fixed order. That order is: precharge all banks, extended mode write (DLL on), mode write with DLL reset, precharge all banks again, a run of auto-refreshes, and a final mode write that carries the operating settings.

Each gap between commands is filled with no-operation cycles. A single down-counter times every wait: the stabilization interval, the precharge and refresh recovery times, and the 200-cycle DLL lock window. The lock window is folded into the gap after the last refresh. When the last mode write has settled, a ready flag rises and stays high until the next reset. Start requests made after that, or during the sequence, have no effect.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low, and after reset until `start` is seen high, `cke` is 0, `init_done` is 0 and the command bus {cs_n,ras_n,cas_n,we_n} shows no-operation, encoded 4'b0111, with `addr` and `ba` zero.
- R2: The cycle after `start` is sampled in idle begins a wait of CLK_MHZ*STAB_US cycles with `cke` 0 and no-operation. Exactly one no-operation cycle with `cke` 1 follows. `cke` never falls again until reset.
- R3: After the clock-enable cycle, the only commands are, in order: precharge-all, extended mode write, DLL-reset mode write, precharge-all, N_REF auto-refreshes, operating mode write. Encodings are precharge 4'b0010, refresh 4'b0001 and mode write 4'b0000. Every other cycle is no-operation.
- R4: Each precharge-all drives `addr[10]`=1, with all other address bits and `ba` zero. The first one comes in the cycle right after the clock-enable cycle.
- R5: The extended mode write drives `ba`=2'b01 (bank bit 0 set) and `addr` all zero, so bit 0 = 0 selects the DLL as enabled.
- R6: Both mode writes drive `ba`=2'b00. addr[2:0] is the burst-length code (2→001, 4→010, 8→011). addr[3] is the burst type (1 = interleaved). addr[6:4] is the CAS latency code. addr[8] is 1 in the first write and 0 in the final one. All other bits are 0.
- R7: The next command comes exactly 2 cycles after each mode or extended mode write, T_RP cycles after each precharge-all, and T_RFC cycles after each refresh that is not the last.
- R8: The final mode write comes at the later of two points: T_RFC cycles after the last refresh, or DLL_LOCK cycles after the DLL-reset write.
- R9: `init_done` rises 2 cycles after the final mode write and stays 1, with `cke` 1 and no-operation, until reset. A `start` pulse in that time changes nothing.
- R10: A `start` pulse while the sequence is running neither restarts it nor moves any later command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin initialization, sampled in idle only |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus, carries mode words and the precharge-all bit |
| ba | output | 2 | Bank address, selects mode vs extended mode register |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
The outputs are decoded from the state register, so every output of a cycle is known one clock edge after the input that caused it. The first stabilization cycle appears one edge after `start` is sampled. After that, each command is exactly its spacing after the one before it. The bench builds the whole expected schedule as a per-cycle queue, starting from the edge at which `start` is taken. It pops one entry at each falling edge and compares all outputs, so a command that is early or late by even one cycle fails against the entry for that cycle. The readiness flag is expected two cycles after the final mode write and on every later cycle. The distance between the two mode writes is measured from the observed command times.

// File: rtl/ddr_init_pkg.sv
// Shared encodings for the DDR power-up sequencer.
// Assumes a single-rank device with a 2-bit bank address.
package ddr_init_pkg;

    // Command bus value, bit order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_NOP  = 4'b0111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAB,
        ST_CKE_ON,
        ST_PALL_A,
        ST_EMRS,
        ST_MRS_RST,
        ST_PALL_B,
        ST_REF,
        ST_MRS_OP,
        ST_WAIT,
        ST_DONE
    } state_e;

    // Which address/bank word the bus carries
    typedef enum logic [2:0] {
        WD_ZERO,
        WD_PALL,
        WD_EXT,
        WD_MODE_RST,
        WD_MODE_RUN
    } word_e;

    // Burst length to mode register code; unknown lengths map to 8
    function automatic logic [2:0] burst_code(input int len);
        case (len)
            2:       return 3'b001;
            4:       return 3'b010;
            default: return 3'b011;
        endcase
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Shared down-counter for all sequencer waits.
// Load a value N and 'last' is high in the N-th cycle after the load edge.
// Assumes N >= 1; the counter parks at zero when not reloaded.
module seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    // R7
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // R7
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mode_word.sv
// Builds the address and bank-address values for each command kind.
// Mode bits: [2:0] burst code, [3] burst type, [6:4] CAS code, [8] DLL reset.
// Assumes ADDR_W >= 11 so the precharge-all bit exists.
module mode_word
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BURST_LEN = 8,
    parameter int BURST_ILV = 0,
    parameter int CAS_LAT   = 3
) (
    input  word_e             sel,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba
);
    localparam logic [2:0] BL_BITS = burst_code(BURST_LEN);
    localparam logic       BT_BIT  = (BURST_ILV != 0);
    localparam logic [2:0] CL_BITS = 3'(CAS_LAT);
    localparam logic [6:0] BASE    = {CL_BITS, BT_BIT, BL_BITS};

    // Decode the selected word onto the bus
    always_comb begin
        addr = '0;
        ba   = 2'b00;
        case (sel)
            WD_PALL:     addr[10] = 1'b1;
            WD_EXT:      ba = 2'b01;
            WD_MODE_RST: begin
                addr[6:0] = BASE;
                addr[8]   = 1'b1;
            end
            WD_MODE_RUN: addr[6:0] = BASE;
            default:     ;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
// DDR SDRAM power-up initialization sequencer (top).
// Steps the memory through stabilization, clock enable, precharge,
// DLL enable, DLL reset, precharge, refreshes and the final mode write,
// then holds init_done until reset. Outputs are decoded from state.
// Assumes T_RP >= 2, T_RFC >= 2, N_REF >= 1, CLK_MHZ*STAB_US >= 1.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int STAB_US   = 200,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 14,
    parameter int N_REF     = 2,
    parameter int DLL_LOCK  = 200,
    parameter int ADDR_W    = 12,
    parameter int BURST_LEN = 8,
    parameter int BURST_ILV = 0,
    parameter int CAS_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba,
    output logic              init_done
);
    localparam int T_MRD     = 2;
    localparam int STAB_CYC  = CLK_MHZ * STAB_US;
    localparam int LOCK_LEFT = DLL_LOCK - (T_MRD + T_RP + (N_REF - 1) * T_RFC);
    localparam int LAST_GAP  = (LOCK_LEFT > T_RFC) ? LOCK_LEFT : T_RFC;
    localparam int CNT_W     = $clog2(STAB_CYC + DLL_LOCK + T_RFC + T_RP + 2);
    localparam int REF_W     = $clog2(N_REF + 1);
    localparam logic [CNT_W-1:0] LD_STAB = CNT_W'(STAB_CYC);
    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_LAST = CNT_W'(LAST_GAP - 1);

    state_e            state_q, state_d, ret_q, ret_d;
    logic [REF_W-1:0]  ref_q, ref_d;
    logic              t_load, t_last;
    logic [CNT_W-1:0]  t_val;
    cmd_e              cmd;
    word_e             wsel;

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    mode_word #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN),
        .BURST_ILV (BURST_ILV),
        .CAS_LAT   (CAS_LAT)
    ) u_word (
        .sel  (wsel),
        .addr (addr),
        .ba   (ba)
    );

    // State, return target and refresh count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            ref_q   <= ref_d;
        end
    end

    // Next-state logic: each command lasts one cycle, then WAIT covers its gap
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        ref_d   = ref_q;
        t_load  = 1'b0;
        t_val   = '0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_STAB;
                t_load  = 1'b1;
                t_val   = LD_STAB;
            end
            ST_STAB:   if (t_last) state_d = ST_CKE_ON;
            ST_CKE_ON: state_d = ST_PALL_A;
            ST_PALL_A: begin
                state_d = ST_WAIT; ret_d = ST_EMRS; t_load = 1'b1; t_val = LD_RP;
            end
            ST_EMRS: begin
                state_d = ST_WAIT; ret_d = ST_MRS_RST; t_load = 1'b1; t_val = LD_MRD;
            end
            ST_MRS_RST: begin
                state_d = ST_WAIT; ret_d = ST_PALL_B; t_load = 1'b1; t_val = LD_MRD;
            end
            ST_PALL_B: begin
                state_d = ST_WAIT; ret_d = ST_REF; t_load = 1'b1; t_val = LD_RP;
                ref_d   = '0;
            end
            ST_REF: begin
                state_d = ST_WAIT;
                t_load  = 1'b1;
                if (ref_q == REF_W'(N_REF - 1)) begin
                    ret_d = ST_MRS_OP;
                    t_val = LD_LAST;
                end else begin
                    ret_d = ST_REF;
                    t_val = LD_RFC;
                    ref_d = ref_q + 1'b1;
                end
            end
            ST_MRS_OP: begin
                state_d = ST_WAIT; ret_d = ST_DONE; t_load = 1'b1; t_val = LD_MRD;
            end
            ST_WAIT:   if (t_last) state_d = ret_q;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output decode from the current state
    always_comb begin
        cmd  = CMD_NOP;
        wsel = WD_ZERO;
        case (state_q)
            ST_PALL_A, ST_PALL_B: begin cmd = CMD_PALL; wsel = WD_PALL;     end
            ST_EMRS:              begin cmd = CMD_MRS;  wsel = WD_EXT;      end
            ST_MRS_RST:           begin cmd = CMD_MRS;  wsel = WD_MODE_RST; end
            ST_MRS_OP:            begin cmd = CMD_MRS;  wsel = WD_MODE_RUN; end
            ST_REF:               cmd = CMD_REF;
            default:              ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = (state_q != ST_IDLE) && (state_q != ST_STAB);
    assign init_done = (state_q == ST_DONE);

    // Cycles since the DLL-reset write, saturating (assertion support)
    logic [15:0] lock_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_cnt_q <= '0;
        else if (cmd == CMD_MRS && ba == 2'b00 && addr[8])
            lock_cnt_q <= 16'd1;
        else if (lock_cnt_q != '0 && lock_cnt_q != 16'hFFFF)
            lock_cnt_q <= lock_cnt_q + 1'b1;
    end

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R1
    nop_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R4
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[10] && ba == 2'b00));

    // R7
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R8
    dll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == 2'b00 && !addr[8])
            |-> (lock_cnt_q >= 16'(DLL_LOCK)));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && cke));

endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
    localparam int CLK_MHZ   = 200;
    localparam int STAB_US   = 50;
    localparam int T_RP      = 3;
    localparam int T_RFC     = 14;
    localparam int N_REF     = 2;
    localparam int DLL_LOCK  = 200;
    localparam int ADDR_W    = 12;
    localparam int BURST_LEN = 4;
    localparam int BURST_ILV = 1;
    localparam int CAS_LAT   = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [ADDR_W-1:0] addr;
    logic [1:0] ba;

    int errors = 0, checks = 0, cyc = 0;

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STAB_US(STAB_US), .T_RP(T_RP), .T_RFC(T_RFC),
        .N_REF(N_REF), .DLL_LOCK(DLL_LOCK), .ADDR_W(ADDR_W),
        .BURST_LEN(BURST_LEN), .BURST_ILV(BURST_ILV), .CAS_LAT(CAS_LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
        .init_done(init_done)
    );

    always #2.5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R9 watchdog: init not finished, got done=%0b expected 1", init_done);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Expected per-cycle schedule
    logic [3:0]        q_cmd[$];
    logic [ADDR_W-1:0] q_addr[$];
    logic [1:0]        q_ba[$];
    bit                q_cke[$];
    string             q_tag[$];

    function automatic logic [ADDR_W-1:0] mode_val(input bit dll_rst);
        logic [ADDR_W-1:0] w;
        int blc;
        blc = (BURST_LEN == 2) ? 1 : (BURST_LEN == 4) ? 2 : 3;
        w = ADDR_W'(CAS_LAT * 16 + BURST_ILV * 8 + blc);
        if (dll_rst) w = w + ADDR_W'(256);
        return w;
    endfunction

    task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                        input logic [1:0] b, input bit k, input string t);
        q_cmd.push_back(c); q_addr.push_back(a); q_ba.push_back(b);
        q_cke.push_back(k); q_tag.push_back(t);
    endtask

    task automatic push_nops(input int n, input string t);
        for (int i = 0; i < n; i++) push(4'b0111, '0, 2'b00, 1'b1, t);
    endtask

    task automatic build_schedule();
        int t_rst, t_ref, t_mrs;
        for (int i = 0; i < CLK_MHZ * STAB_US; i++) push(4'b0111, '0, 2'b00, 1'b0, "R2");
        push(4'b0111, '0, 2'b00, 1'b1, "R2");
        push(4'b0010, ADDR_W'(1024), 2'b00, 1'b1, "R4");
        push_nops(T_RP - 1, "R7");
        push(4'b0000, '0, 2'b01, 1'b1, "R5");
        push_nops(1, "R7");
        t_rst = q_cmd.size();
        push(4'b0000, mode_val(1'b1), 2'b00, 1'b1, "R6");
        push_nops(1, "R7");
        push(4'b0010, ADDR_W'(1024), 2'b00, 1'b1, "R4");
        push_nops(T_RP - 1, "R7");
        t_ref = 0;
        for (int r = 0; r < N_REF; r++) begin
            t_ref = q_cmd.size();
            push(4'b0001, '0, 2'b00, 1'b1, "R3");
            if (r < N_REF - 1) push_nops(T_RFC - 1, "R7");
        end
        t_mrs = t_ref + T_RFC;
        if (t_rst + DLL_LOCK > t_mrs) t_mrs = t_rst + DLL_LOCK;
        push_nops(t_mrs - t_ref - 1, "R8");
        push(4'b0000, mode_val(1'b0), 2'b00, 1'b1, "R6");
        push_nops(1, "R7");
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(tag, "idle cke", {31'd0, cke}, 0);
        check(tag, "idle cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check(tag, "idle done", {31'd0, init_done}, 0);
        check(tag, "idle addr/ba", {18'd0, addr, ba}, 0);
    endtask

    int done_idx[2];

    // Run one full sequence; run 1 injects start pulses mid-sequence (R10)
    task automatic run_sequence(input int run);
        int n, i_rst, i_fin, n_ref, mrs_seen;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        build_schedule();
        n = q_cmd.size();
        i_rst = -1; i_fin = -1; n_ref = 0; mrs_seen = 0;
        for (int i = 0; i < n; i++) begin
            string t;
            t = q_tag.pop_front();
            if (run == 1 && (i == 37 || i == n - 5)) t = "R10";
            check(t, "cke", {31'd0, cke}, {31'd0, q_cke.pop_front()});
            check(t, "cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, q_cmd.pop_front()});
            check(t, "addr", {20'd0, addr}, {20'd0, q_addr.pop_front()});
            check(t, "ba", {30'd0, ba}, {30'd0, q_ba.pop_front()});
            check(t, "done low", {31'd0, init_done}, 0);
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) n_ref++;
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == 2'b00) begin
                if (mrs_seen == 0) i_rst = i; else i_fin = i;
                mrs_seen++;
            end
            start = (run == 1 && (i == 36 || i == n - 6)) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        done_idx[run] = n;
        check("R3", "refresh count", n_ref, N_REF);
        check("R8", "lock window ok", {31'd0, (i_fin - i_rst) >= DLL_LOCK}, 1);
        // R9: done now, held with NOP and cke high, start pulses ignored
        for (int i = 0; i < 40; i++) begin
            check("R9", "done held", {31'd0, init_done}, 1);
            check("R9", "cke held", {31'd0, cke}, 1);
            check("R9", "nop after done", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
            start = (i % 7 == 3);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;                       // R1: start ignored in reset
        @(negedge clk);
        check_idle("R1");
        start = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin   // R1: idle without start
            @(negedge clk);
            check_idle("R1");
        end
        run_sequence(0);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        run_sequence(1);
        check("R10", "same length", done_idx[1], done_idx[0]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule